// File: doc/BRIEF.md
# Supply Low-Voltage Reset Controller

This block is the digital side of a supply-voltage monitor. Two analog comparators report whether the supply has fallen below a falling trip level and whether it has risen above a higher rising trip level. Both inputs are asynchronous. The block passes each one through a two-stage synchronizer. It then produces three outputs: a registered low-voltage status flag that software can poll, a glitch-free chip reset request, and a trip-range select output that tells the analog side whether to use the high-supply or the low-supply thresholds.

A four-bit configuration register holds the control bits and is written through a single-cycle write strobe. One bit powers the monitor down. One bit disables resets, which leaves the block in polled-only mode. One bit selects the high-supply trip range. One bit keeps the monitor running while the chip is in stop mode. Once a reset request has been raised, it is held until the supply climbs past the rising level. The gap between the falling and rising levels is the hysteresis, and it keeps the chip from dropping in and out of reset.

Power-on reset is asynchronous, active low, and released synchronously inside the block. It clears the configuration, so the monitor starts enabled, with resets allowed and with the low-supply range selected.

Top module: `vmon_reset_ctrl`

## Requirements
- R1: When configuration bit 0 (power-down) is 1, the status flag and the reset request are both 0 from the second clock edge after the write onward, whatever the comparator inputs do.
- R2: When bit 1 (reset-disable) is 1 and the monitor is active, the flag follows the below-falling input three clock edges after it changes, and the reset request stays 0.
- R3: With bits 0 and 1 both 0, a rise of the below-falling input sets the reset request on the third clock edge after the input changes.
- R4: Once set, the reset request stays 1 while the above-rising input is 0, even after the below-falling input returns to 0.
- R5: The trip-range output equals configuration bit 2 (1 = high-supply levels, 0 = low-supply levels) and reads 0 after power-on reset.
- R6: Selecting the high-supply range while the below-falling input reports low supply raises the reset request when resets are enabled.
- R7: While the stop-mode input is 1 and bit 3 (stop-enable) is 0, the monitor is inactive: the flag reads 0 and any held reset request is dropped. With bit 3 at 1 the monitor works normally during stop.
- R8: Power-on reset clears the configuration register and the reset-hold state. All three outputs read 0 once reset is released.
- R9: A held reset request is released on the third clock edge after the above-rising input goes to 1, provided the below-falling input is 0.
- R10: Writing the configuration updates the register on the strobed edge. The new bits govern the flag and the reset request from the following edge.
- R11: If both comparator inputs are 1 in the same cycle, setting takes priority over release, and the reset request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| cmp_below_fall_i | input | 1 | Asynchronous comparator: supply below falling trip level |
| cmp_above_rise_i | input | 1 | Asynchronous comparator: supply above rising trip level |
| stop_mode_i | input | 1 | Chip is in stop mode |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration data: bit0 power-down, bit1 reset-disable, bit2 high range, bit3 stop-enable |
| range_hi_o | output | 1 | Trip-range select to the analog comparators |
| low_flag_o | output | 1 | Pollable low-voltage status flag |
| reset_req_o | output | 1 | Registered chip reset request |

## Verification
A set and a release of the reset hold can fall in the same cycle. The bench provokes this by raising both comparator inputs together, both from the idle state and while a reset is already held, and it expects the request to assert or stay asserted. A configuration write and a pending release or assertion can also land on neighbouring edges. The bench writes reset-disable while a request is held, then samples edge by edge to confirm that the old setting governs one more edge and the new one governs the next.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  localparam int unsigned CFG_W       = 4;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES  = 2;
  localparam int unsigned CMP_W       = 2;

  localparam int unsigned CMP_BELOW = 0;
  localparam int unsigned CMP_ABOVE = 1;

  typedef struct packed {
    logic stop_en;
    logic hi_range;
    logic rst_dis;
    logic pwr_dn;
  } vmon_cfg_t;

  typedef enum logic {
    HOLD_CLEAR = 1'b0,
    HOLD_SET   = 1'b1
  } vmon_hold_e;

endpackage

// File: rtl/vmon_rst_sync.sv
module vmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[LAST];

endmodule

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;

    if (s == 0) begin : g_first
      always_comb stage_d = async_i;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/vmon_cfg_reg.sv
module vmon_cfg_reg
  import vmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output vmon_cfg_t        cfg_o
);

  vmon_cfg_t cfg_q;
  vmon_cfg_t cfg_d;
  logic      cfg_en;

  always_comb begin
    cfg_en = wr_i;
    cfg_d  = vmon_cfg_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R10: a write lands in the register on the strobed edge
  p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cfg_q == $past(wdata_i)));

  // R10: without a strobe the register holds its value
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cfg_q));

endmodule

// File: rtl/vmon_trip_ctrl.sv
module vmon_trip_ctrl
  import vmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  vmon_cfg_t cfg_i,
  input  logic      stop_mode_i,
  input  logic      below_i,
  input  logic      above_i,
  output logic      flag_o,
  output logic      req_o
);

  logic       mon_active;
  logic       rst_allowed;
  vmon_hold_e hold_q;
  vmon_hold_e hold_d;
  logic       flag_q;
  logic       flag_d;

  // The monitor runs when it is not powered down, and during stop only when
  // stop operation is enabled.
  always_comb begin
    mon_active  = !cfg_i.pwr_dn && (!stop_mode_i || cfg_i.stop_en);
    rst_allowed = mon_active && !cfg_i.rst_dis;
  end

  // Next-state logic. Setting wins over release; losing permission drops the hold.
  always_comb begin
    hold_d = hold_q;
    if (!rst_allowed) begin
      hold_d = HOLD_CLEAR;
    end else if (below_i) begin
      hold_d = HOLD_SET;
    end else if ((hold_q == HOLD_SET) && above_i) begin
      hold_d = HOLD_CLEAR;
    end
    flag_d = mon_active && below_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HOLD_CLEAR;
      flag_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      flag_q <= flag_d;
    end
  end

  assign req_o  = (hold_q == HOLD_SET);
  assign flag_o = flag_q;

  // R1: a powered-down monitor produces neither flag nor reset
  p_pwrdn_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.pwr_dn |=> (!req_o && !flag_o));

  // R2: polled mode never requests a reset
  p_polled_no_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_active && cfg_i.rst_dis) |=> !req_o);

  // R4: the hold persists while the rising level has not been crossed
  p_hold_until_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !above_i && rst_allowed) |=> req_o);

  // R9: crossing the rising level releases the hold on the next edge
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && above_i && !below_i && rst_allowed) |=> !req_o);

  // R11: a low-supply report sets the hold even if release is also seen
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_allowed && below_i) |=> req_o);

  // R7: stop without stop operation quiets both outputs
  p_stop_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode_i && !cfg_i.stop_en) |=> (!req_o && !flag_o));

endmodule

// File: rtl/vmon_reset_ctrl.sv
module vmon_reset_ctrl
  import vmon_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             cmp_below_fall_i,
  input  logic             cmp_above_rise_i,
  input  logic             stop_mode_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             range_hi_o,
  output logic             low_flag_o,
  output logic             reset_req_o
);

  logic             rst_n;
  logic [CMP_W-1:0] cmp_async;
  logic [CMP_W-1:0] cmp_sync;
  vmon_cfg_t        cfg;

  vmon_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_n)
  );

  always_comb begin
    cmp_async            = '0;
    cmp_async[CMP_BELOW] = cmp_below_fall_i;
    cmp_async[CMP_ABOVE] = cmp_above_rise_i;
  end

  vmon_sync #(
    .WIDTH  (CMP_W),
    .STAGES (SYNC_STAGES)
  ) u_cmp_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_async),
    .sync_o  (cmp_sync)
  );

  vmon_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  vmon_trip_ctrl u_trip (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg),
    .stop_mode_i (stop_mode_i),
    .below_i     (cmp_sync[CMP_BELOW]),
    .above_i     (cmp_sync[CMP_ABOVE]),
    .flag_o      (low_flag_o),
    .req_o       (reset_req_o)
  );

  assign range_hi_o = cfg.hi_range;

  // R5: a write of the range bit reaches the analog select on the next edge
  p_range_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> (range_hi_o == $past(cfg_wdata_i[2])));

  // R8: while reset is applied the outputs are quiet
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!reset_req_o && !low_flag_o && !range_hi_o));

endmodule

// File: tb/vmon_reset_ctrl_bench.sv
module vmon_reset_ctrl_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 12;
  localparam int  WATCHDOG   = 200000;

  // Vector layout: [10] below, [9] above, [8] stop, [7] wr, [6:3] wdata,
  //                [2] exp flag, [1] exp req, [0] exp range
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_1_0_0_0000_0_0_0, // idle, supply good
    11'b1_0_0_0_0000_1_1_0, // R3 drop asserts reset
    11'b0_0_0_0_0000_0_1_0, // R4 held between levels
    11'b0_1_0_0_0000_0_0_0, // R9 rise releases
    11'b1_0_0_1_0010_1_0_0, // R2 polled: flag only
    11'b0_1_0_0_0000_0_0_0, // R2 flag follows back down
    11'b1_0_0_1_0001_0_0_0, // R1 powered down
    11'b0_1_0_1_0100_0_0_1, // R5 high range selected
    11'b1_0_0_0_0000_1_1_1, // R6 low against high range
    11'b1_0_1_0_0000_0_0_1, // R7 stop without stop-enable
    11'b1_0_1_1_1100_1_1_1, // R7 stop with stop-enable
    11'b0_1_0_0_0000_0_0_1  // R9 release in high range
  };

  logic       clk;
  logic       por_n;
  logic       below;
  logic       above;
  logic       stop;
  logic       wr;
  logic [3:0] wdata;
  logic       range_hi;
  logic       flag;
  logic       req;

  int checks;
  int fails;

  vmon_reset_ctrl u_vmon_reset_ctrl (
    .clk              (clk),
    .por_n            (por_n),
    .cmp_below_fall_i (below),
    .cmp_above_rise_i (above),
    .stop_mode_i      (stop),
    .cfg_wr_i         (wr),
    .cfg_wdata_i      (wdata),
    .range_hi_o       (range_hi),
    .low_flag_o       (flag),
    .reset_req_o      (req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] d);
    wr    = 1'b1;
    wdata = d;
    step(1);
    wr    = 1'b0;
  endtask

  initial begin
    step(WATCHDOG);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    por_n  = 1'b0;
    below  = 1'b0;
    above  = 1'b0;
    stop   = 1'b0;
    wr     = 1'b0;
    wdata  = '0;
    step(3);
    por_n = 1'b1;
    step(4);

    // R8 reset state
    check("R8 range after reset", range_hi, 1'b0);
    check("R8 flag after reset", flag, 1'b0);
    check("R8 req after reset", req, 1'b0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      below = VEC[i][10];
      above = VEC[i][9];
      stop  = VEC[i][8];
      wr    = VEC[i][7];
      wdata = VEC[i][6:3];
      step(1);
      wr = 1'b0;
      step(4);
      check($sformatf("vec%0d flag R1/R2/R3/R7", i), flag, VEC[i][2]);
      check($sformatf("vec%0d req R3/R4/R6/R9", i), req, VEC[i][1]);
      check($sformatf("vec%0d range R5", i), range_hi, VEC[i][0]);
    end

    // R8: power-on reset in the middle of a hold with high range selected
    below = 1'b1;
    above = 1'b0;
    write_cfg(4'b0100);
    step(4);
    check("R8 req held before reset", req, 1'b1);
    below = 1'b0;
    por_n = 1'b0;
    step(1);
    check("R8 req during reset", req, 1'b0);
    por_n = 1'b1;
    step(4);
    check("R8 range cleared", range_hi, 1'b0);
    check("R8 req cleared", req, 1'b0);

    // R3: assertion on the third edge after the input rises
    below = 1'b1;
    step(2);
    check("R3 req not yet after two edges", req, 1'b0);
    step(1);
    check("R3 req on third edge", req, 1'b1);
    check("R2 flag on third edge", flag, 1'b1);

    // R9: release on the third edge after the rising input goes high
    below = 1'b0;
    above = 1'b1;
    step(2);
    check("R9 req still held after two edges", req, 1'b1);
    step(1);
    check("R9 req released on third edge", req, 1'b0);

    // R10: configuration takes effect one edge after the write
    above = 1'b0;
    below = 1'b1;
    step(4);
    check("R10 req held before write", req, 1'b1);
    wr    = 1'b1;
    wdata = 4'b0010;
    step(1);
    wr = 1'b0;
    check("R10 old cfg governs write edge", req, 1'b1);
    step(1);
    check("R10 new cfg drops req", req, 1'b0);
    check("R10 flag kept in polled mode", flag, 1'b1);

    // R11: set and release in the same cycle
    write_cfg(4'b0000);
    below = 1'b0;
    above = 1'b1;
    step(4);
    check("R11 idle before collision", req, 1'b0);
    below = 1'b1;
    step(3);
    check("R11 both inputs from idle set req", req, 1'b1);
    step(4);
    check("R11 both inputs keep req held", req, 1'b1);

    // R1: power-down with both inputs active drops everything
    write_cfg(4'b0001);
    step(1);
    check("R1 req dropped by power-down", req, 1'b0);
    check("R1 flag dropped by power-down", flag, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule